// File: doc/BRIEF.md
# Dual-Mode Video IF Gain Controller

This block produces the gain code for the IF multiplier of an analog-TV demodulator. Each clock it receives one signed IF envelope sample, the lock flag of the sync PLL, a back-porch gate strobe, an update strobe and a field strobe. When sync is locked, a control input selects one of two ways of measuring the signal. The gated detector integrates the black-level error during the back porch. The peak detector responds fast to overload and recovers slowly.

While sync is unlocked, the selected mode is ignored and the block runs a peak search that is updated once per field. This search pulls the gain down whenever the signal overloads, so acquisition can leave saturation. The gain code is clamped to its legal range, and a one-cycle flag reports every update that hit a limit. Steps, shift amount and target level are plain register inputs. They take effect only on the cycle an update is applied.

Top module: `video_if_gain_ctl`

## Requirements
- R1: While rst is high at a clock edge, the gain code becomes 80 (0 dB), sat_o becomes 0, and the peak and error accumulators are cleared.
- R2: gain_o is a 9-bit unsigned code at 0.25 dB per LSB, where code 0 means -20 dB. Its value is always within 0..272, and 272 means +48 dB.
- R3: In peak mode (mode_i = 1) with sync locked, an update strobe lowers the gain by attack_i when the held peak magnitude is above target_i.
- R4: In peak mode with sync locked, an update raises the gain by decay_i when the held peak is below target_i, and leaves it unchanged when the peak equals target_i.
- R5: The held peak is the largest absolute sample value seen since the last applied update, so negative samples count by magnitude. It restarts from zero after each applied update, and the sample present on the update cycle itself is discarded.
- R6: In gated mode (mode_i = 0) with sync locked, the error target_i - |sample| is added to a saturating accumulator only on cycles where gate_i is high. Samples taken with gate_i low have no effect.
- R7: In gated mode with sync locked, an update adds the accumulator, arithmetically right-shifted by shift_i (rounding toward minus infinity), to the gain. The accumulator then clears.
- R8: While sync_lock_i is low, mode_i is ignored and gated samples are not accumulated. A field strobe applies the peak rule of R3/R4 using attack_i and decay_i.
- R9: While sync_lock_i is high, fld_i has no effect. While it is low, upd_i has no effect.
- R10: sat_o is high for exactly the cycle after an update whose unclamped result was below 0 or above 272. In that case the gain is clamped to the limit it crossed.
- R11: On cycles with no applied update, the gain code holds its value whatever the samples and gate do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_i | input | SAMP_W | Signed IF envelope sample |
| sync_lock_i | input | 1 | Sync PLL locked |
| gate_i | input | 1 | Back-porch gate strobe |
| upd_i | input | 1 | Update strobe, used while locked |
| fld_i | input | 1 | Field strobe, used while unlocked |
| mode_i | input | 1 | 0 = gated black level, 1 = peak |
| target_i | input | SAMP_W | Target magnitude (unsigned) |
| attack_i | input | STEP_W | Gain decrease step |
| decay_i | input | STEP_W | Gain increase step |
| shift_i | input | SHIFT_W | Integrator right-shift amount |
| gain_o | output | 9 | Clamped gain code |
| sat_o | output | 1 | One-cycle clamp flag |

## Verification
The bench uses the default parameters: 12-bit samples, a 20-bit accumulator, 8-bit steps and a 4-bit shift. With a target near 1000, a single gated sample at shift 0 can carry the gain straight to the upper limit. One attack step of 200 can drive it under zero, so both clamps and the flag are reached in a few cycles. Small negative accumulations at shift 3 show that the shift rounds toward minus infinity. Full-scale negative samples show that the peak is taken by magnitude.

// File: rtl/agc_pkg.sv
package agc_pkg;

    localparam int GAIN_W   = 9;
    localparam int GAIN_MAX = 272;
    localparam int GAIN_RST = 80;

    typedef enum logic {
        DET_GATED = 1'b0,
        DET_PEAK  = 1'b1
    } det_mode_e;

    typedef enum logic [1:0] {
        UPD_NONE  = 2'd0,
        UPD_INTEG = 2'd1,
        UPD_STEP  = 2'd2
    } upd_kind_e;

    typedef struct packed {
        logic [GAIN_W-1:0] code;
        logic              sat;
    } gain_res_t;

    function automatic gain_res_t clamp_gain(input logic signed [31:0] s);
        gain_res_t r;
        if (s < 0) begin
            r.code = '0;
            r.sat  = 1'b1;
        end else if (s > GAIN_MAX) begin
            r.code = GAIN_W'(GAIN_MAX);
            r.sat  = 1'b1;
        end else begin
            r.code = s[GAIN_W-1:0];
            r.sat  = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/agc_peak_hold.sv
module agc_peak_hold #(
    parameter int SAMP_W = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [SAMP_W-1:0] samp_i,
    input  logic                     clr_i,
    output logic [SAMP_W-1:0]        mag_o,
    output logic [SAMP_W-1:0]        peak_o
);
    logic [SAMP_W-1:0] peak_q;

    always_comb begin
        if (samp_i[SAMP_W-1])
            mag_o = ~samp_i + 1'b1;
        else
            mag_o = samp_i;
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i)
            peak_q <= '0;
        else if (mag_o > peak_q)
            peak_q <= mag_o;
    end

    assign peak_o = peak_q;

    // R5
    peak_monotone_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> peak_o >= $past(peak_o));

endmodule

// File: rtl/agc_gate_integ.sv
module agc_gate_integ #(
    parameter int SAMP_W = 12,
    parameter int ACC_W  = 20
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [SAMP_W-1:0]       mag_i,
    input  logic [SAMP_W-1:0]       target_i,
    input  logic                    en_i,
    input  logic                    clr_i,
    output logic signed [ACC_W-1:0] acc_o
);
    localparam int ERR_W = SAMP_W + 1;

    logic signed [ERR_W-1:0] err;
    logic signed [ACC_W:0]   sum;
    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] acc_sat;

    always_comb begin
        err = $signed({1'b0, target_i}) - $signed({1'b0, mag_i});
        sum = $signed({acc_q[ACC_W-1], acc_q}) + (ACC_W+1)'(err);
        if (sum[ACC_W] != sum[ACC_W-1])
            acc_sat = sum[ACC_W] ? {1'b1, {(ACC_W-1){1'b0}}}
                                 : {1'b0, {(ACC_W-1){1'b1}}};
        else
            acc_sat = sum[ACC_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i)
            acc_q <= '0;
        else if (en_i)
            acc_q <= acc_sat;
    end

    assign acc_o = acc_q;

    // R6
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!en_i && !clr_i) |=> $stable(acc_o));

endmodule

// File: rtl/agc_gain_core.sv
module agc_gain_core
    import agc_pkg::*;
#(
    parameter int SAMP_W  = 12,
    parameter int ACC_W   = 20,
    parameter int STEP_W  = 8,
    parameter int SHIFT_W = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  upd_kind_e               kind_i,
    input  logic [SAMP_W-1:0]       peak_i,
    input  logic [SAMP_W-1:0]       target_i,
    input  logic signed [ACC_W-1:0] acc_i,
    input  logic [STEP_W-1:0]       attack_i,
    input  logic [STEP_W-1:0]       decay_i,
    input  logic [SHIFT_W-1:0]      shift_i,
    output logic [GAIN_W-1:0]       gain_o,
    output logic                    sat_o
);
    logic signed [31:0] acc_ext;
    logic signed [31:0] delta;
    logic signed [31:0] sum;
    gain_res_t          res;
    logic [GAIN_W-1:0]  gain_q;
    logic               sat_q;

    always_comb begin
        acc_ext = 32'(acc_i);
        delta   = '0;
        unique case (kind_i)
            UPD_INTEG: delta = acc_ext >>> shift_i;
            UPD_STEP: begin
                if (peak_i > target_i)
                    delta = -$signed(32'(attack_i));
                else if (peak_i < target_i)
                    delta = $signed(32'(decay_i));
            end
            default: delta = '0;
        endcase
        sum = $signed(32'(gain_q)) + delta;
        res = clamp_gain(sum);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gain_q <= GAIN_W'(GAIN_RST);
            sat_q  <= 1'b0;
        end else if (kind_i != UPD_NONE) begin
            gain_q <= res.code;
            sat_q  <= res.sat;
        end else begin
            sat_q  <= 1'b0;
        end
    end

    assign gain_o = gain_q;
    assign sat_o  = sat_q;

    // R3
    attack_down_chk: assert property (@(posedge clk) disable iff (rst)
        (kind_i == UPD_STEP && peak_i > target_i) |=> gain_o <= $past(gain_o));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (kind_i == UPD_NONE) |=> ($stable(gain_o) && !sat_o));

endmodule

// File: rtl/video_if_gain_ctl.sv
module video_if_gain_ctl
    import agc_pkg::*;
#(
    parameter int SAMP_W  = 12,
    parameter int ACC_W   = 20,
    parameter int STEP_W  = 8,
    parameter int SHIFT_W = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [SAMP_W-1:0] samp_i,
    input  logic                     sync_lock_i,
    input  logic                     gate_i,
    input  logic                     upd_i,
    input  logic                     fld_i,
    input  logic                     mode_i,
    input  logic [SAMP_W-1:0]        target_i,
    input  logic [STEP_W-1:0]        attack_i,
    input  logic [STEP_W-1:0]        decay_i,
    input  logic [SHIFT_W-1:0]       shift_i,
    output logic [8:0]               gain_o,
    output logic                     sat_o
);
    det_mode_e               mode;
    upd_kind_e               kind;
    logic                    clr;
    logic                    integ_en;
    logic [SAMP_W-1:0]       mag;
    logic [SAMP_W-1:0]       peak;
    logic signed [ACC_W-1:0] acc;
    logic [GAIN_W-1:0]       gain;

    assign mode = det_mode_e'(mode_i);

    always_comb begin
        kind = UPD_NONE;
        if (sync_lock_i) begin
            if (upd_i)
                kind = (mode == DET_PEAK) ? UPD_STEP : UPD_INTEG;
        end else if (fld_i) begin
            kind = UPD_STEP;
        end
    end

    assign clr      = (kind != UPD_NONE);
    assign integ_en = sync_lock_i && (mode == DET_GATED) && gate_i && !clr;

    agc_peak_hold #(.SAMP_W(SAMP_W)) u_peak (
        .clk    (clk),
        .rst    (rst),
        .samp_i (samp_i),
        .clr_i  (clr),
        .mag_o  (mag),
        .peak_o (peak)
    );

    agc_gate_integ #(.SAMP_W(SAMP_W), .ACC_W(ACC_W)) u_integ (
        .clk      (clk),
        .rst      (rst),
        .mag_i    (mag),
        .target_i (target_i),
        .en_i     (integ_en),
        .clr_i    (clr),
        .acc_o    (acc)
    );

    agc_gain_core #(
        .SAMP_W(SAMP_W), .ACC_W(ACC_W), .STEP_W(STEP_W), .SHIFT_W(SHIFT_W)
    ) u_core (
        .clk      (clk),
        .rst      (rst),
        .kind_i   (kind),
        .peak_i   (peak),
        .target_i (target_i),
        .acc_i    (acc),
        .attack_i (attack_i),
        .decay_i  (decay_i),
        .shift_i  (shift_i),
        .gain_o   (gain),
        .sat_o    (sat_o)
    );

    assign gain_o = gain;

    // R2
    gain_range_chk: assert property (@(posedge clk) disable iff (rst)
        gain_o <= 9'(GAIN_MAX));

    // R10
    sat_limit_chk: assert property (@(posedge clk) disable iff (rst)
        sat_o |-> (gain_o == '0 || gain_o == 9'(GAIN_MAX)));

    // R9
    unlocked_upd_chk: assert property (@(posedge clk) disable iff (rst)
        (!sync_lock_i && !fld_i) |=> $stable(gain_o));

    // R9
    locked_fld_chk: assert property (@(posedge clk) disable iff (rst)
        (sync_lock_i && !upd_i) |=> $stable(gain_o));

endmodule

// File: tb/sim_video_if_gain_ctl.sv
`timescale 1ns/1ps
module sim_video_if_gain_ctl;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic signed [11:0] samp = '0;
    logic              lock = 1'b1;
    logic              gate = 1'b0;
    logic              upd = 1'b0;
    logic              fld = 1'b0;
    logic              mode = 1'b1;
    logic [11:0]       target = 12'd1000;
    logic [7:0]        attack = 8'd20;
    logic [7:0]        decay = 8'd2;
    logic [3:0]        shift = 4'd3;
    logic [8:0]        gain;
    logic              sat;

    int checks = 0;
    int errors = 0;
    int exp_gain = 80;

    always #2 clk = ~clk;

    video_if_gain_ctl u0 (
        .clk(clk), .rst(rst), .samp_i(samp), .sync_lock_i(lock), .gate_i(gate),
        .upd_i(upd), .fld_i(fld), .mode_i(mode), .target_i(target),
        .attack_i(attack), .decay_i(decay), .shift_i(shift),
        .gain_o(gain), .sat_o(sat)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input int s, input logic g);
        @(negedge clk);
        samp = 12'(s);
        gate = g;
    endtask

    task automatic pulse_upd();
        @(negedge clk);
        samp = '0; gate = 1'b0; upd = 1'b1;
        @(negedge clk);
        upd = 1'b0;
    endtask

    task automatic pulse_fld();
        @(negedge clk);
        samp = '0; gate = 1'b0; fld = 1'b1;
        @(negedge clk);
        fld = 1'b0;
    endtask

    task automatic apply(input int delta, input string req);
        int s = exp_gain + delta;
        int es = 0;
        if (s < 0) begin s = 0; es = 1; end
        if (s > 272) begin s = 272; es = 1; end
        exp_gain = s;
        check(req, gain, exp_gain);
        check(req, sat, es);
    endtask

    task automatic t_reset();
        check("R1", gain, 80);
        check("R1", sat, 0);
    endtask

    task automatic t_peak_attack();
        lock = 1; mode = 1; target = 1000; attack = 20; decay = 2;
        drive(1500, 0); drive(300, 0);
        pulse_upd(); apply(-20, "R3");
        drive(-1800, 0);
        pulse_upd(); apply(-20, "R5 negative magnitude");
    endtask

    task automatic t_peak_decay();
        drive(500, 0);
        pulse_upd(); apply(2, "R4 decay");
        drive(1000, 0); drive(200, 0);
        pulse_upd(); apply(0, "R4 equal");
    endtask

    task automatic t_peak_clear();
        drive(1900, 0);
        pulse_upd(); apply(-20, "R5 attack");
        drive(400, 0);
        pulse_upd(); apply(2, "R5 cleared");
    endtask

    task automatic t_gated();
        mode = 0; shift = 3;
        for (int i = 0; i < 8; i++) drive(900, 1);
        for (int i = 0; i < 5; i++) drive(0, 0);
        @(negedge clk);
        check("R11 idle", gain, exp_gain);
        pulse_upd(); apply(100, "R6 gated sum");
        for (int i = 0; i < 8; i++) drive(1100, 1);
        pulse_upd(); apply(-100, "R7 negative");
        drive(1006, 1); drive(1006, 1);
        pulse_upd(); apply(-2, "R7 floor shift");
    endtask

    task automatic t_upper();
        shift = 0;
        drive(0, 1);
        pulse_upd(); apply(1000, "R10 upper");
        @(negedge clk);
        check("R10 one cycle", sat, 0);
        check("R2 upper", gain, 272);
    endtask

    task automatic t_lower();
        mode = 1; attack = 200;
        drive(2000, 0);
        pulse_upd(); apply(-200, "R3 big");
        drive(2000, 0);
        pulse_upd(); apply(-200, "R10 lower");
        @(negedge clk);
        check("R10 one cycle low", sat, 0);
    endtask

    task automatic t_unlock();
        lock = 0; mode = 0; attack = 20; decay = 30; shift = 0;
        drive(300, 1); drive(300, 1);
        pulse_upd();
        check("R9 upd ignored", gain, exp_gain);
        pulse_fld(); apply(30, "R8 search decay");
        drive(1500, 1);
        pulse_fld(); apply(-20, "R8 search attack");
    endtask

    task automatic t_locked_fld();
        lock = 1; mode = 1; attack = 5;
        drive(1500, 0);
        pulse_fld();
        check("R9 fld ignored", gain, exp_gain);
        pulse_upd(); apply(-5, "R3 after fld");
        mode = 0;
        drive(0, 0); drive(0, 0);
        pulse_upd(); apply(0, "R6 ungated");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_peak_attack();
        t_peak_decay();
        t_peak_clear();
        t_gated();
        t_upper();
        t_lower();
        t_unlock();
        t_locked_fld();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        checks++;
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule